// File: doc/BRIEF.md
# Programmable Triangle Profile Generator

This block produces the digital frequency-offset word for a spread-spectrum clock generator. The offset feeds a downstream noise-shaping modulator and loop, which turn it into a clock that swings below its nominal frequency. The clock therefore moves from nominal down toward (1−δ) times nominal and back, which is down-spread. The block's output is a staircase of fractional offsets that traces a triangle: it climbs from zero to a programmed peak, reverses, and falls back to zero. The downstream loop smooths the staircase. The block itself only steps.

An internal divider turns the reference clock into step events. The number of reference cycles between steps is chosen by a modulation-frequency select. The select covers 30 kHz to 300 kHz, and each triangle holds a fixed number of steps. A spread select covers 2500 ppm to 50000 ppm. It fixes the step size, and with it the peak offset, on a fractional word of `OFS_W` bits. A level `start_i` runs the ramp. `bypass_i` forces the offset to zero. Flags report when the ramp sits on its top or bottom corner. New selections are only taken while the ramp rests at zero, so reprogramming never produces a jump.

Top module: `tri_profile_gen`

## Requirements
- R1: After reset, `offset_o` is 0, `at_bottom_o` is 1, `at_top_o` is 0 and `step_o` is 0.
- R2: While running, successive steps are exactly `max(1, floor(REF_KHZ / (2*HALF_STEPS*f)))` clock cycles apart, where `fmod_sel_i` values 0, 1, 2 and 3 select f = 30, 60, 150 and 300 kHz. With the defaults this gives 26, 13, 5 and 2 cycles. The first step after a start from zero comes the same number of cycles after `start_i` rises.
- R3: The step size is `max(1, floor(ppm * 2^OFS_W / (10^6 * HALF_STEPS)))`, where `spread_sel_i` values 0, 1, 2 and 3 select ppm = 2500, 10000, 25000 and 50000. With the defaults this gives 2, 10, 25 and 51. On the rising side, step k sets the offset to k times the step size.
- R4: The peak is the step size times `HALF_STEPS`. The offset never exceeds it. The offset reaches the peak on step `HALF_STEPS` and falls by one step size on the next step. `at_top_o` is high exactly while the offset equals the peak.
- R5: On the falling side the offset decreases by the step size and reaches 0 on step `2*HALF_STEPS`, then rises again. `at_bottom_o` is high whenever the offset is 0.
- R6: `step_o` is a single-cycle pulse in the cycle the new offset appears. Apart from the clear caused by bypass, the offset changes in no other cycle.
- R7: A change of either select while the offset is non-zero has no effect on the current triangle. It takes effect on the first step after the ramp returns to zero.
- R8: A select change presented in the clock cycle in which the ramp steps away from zero is not captured for that triangle. It is applied on the next return to zero.
- R9: When `start_i` falls mid-ramp, the ramp completes its triangle down to 0 and then stops. No further `step_o` pulses occur.
- R10: With `start_i` low and the offset at 0, no steps occur.
- R11: While `bypass_i` is high, the offset is 0 from the following cycle on and no steps occur. After release with `start_i` high, the ramp restarts upward from 0 with the timing of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Level run request for the ramp |
| bypass_i | input | 1 | Force zero offset and clear the ramp |
| fmod_sel_i | input | 2 | Modulation-frequency select (step interval) |
| spread_sel_i | input | 2 | Spread select (step size and peak) |
| offset_o | output | OFS_W | Fractional frequency-offset word |
| step_o | output | 1 | Pulse marking a new offset value |
| at_top_o | output | 1 | Offset equals the programmed peak |
| at_bottom_o | output | 1 | Offset is zero |

## Verification
The selection capture at zero and the step that leaves zero can land in the same clock cycle. The capture is allowed only in zero cycles without a step, so a select change in the leaving cycle must miss the current triangle. The bench provokes this with the two-cycle step interval. It waits for the arrival at zero, lets one quiet cycle pass, and changes the spread select in the cycle of the leaving step. It then judges the outcome by the first offset after leaving, the old peak reached mid-ramp, and the new step size appearing only after the following return to zero.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    localparam int SEL_W = 2;
    localparam int N_SEL = 1 << SEL_W;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } ramp_dir_e;

    // modulation frequency per select, in kHz
    function automatic longint unsigned mod_khz(input int unsigned sel);
        case (sel)
            0:       return 64'd30;
            1:       return 64'd60;
            2:       return 64'd150;
            default: return 64'd300;
        endcase
    endfunction

    // spread per select, in ppm of nominal
    function automatic longint unsigned spread_ppm(input int unsigned sel);
        case (sel)
            0:       return 64'd2500;
            1:       return 64'd10000;
            2:       return 64'd25000;
            default: return 64'd50000;
        endcase
    endfunction

    // reference cycles per step
    function automatic longint unsigned div_ratio(input longint unsigned ref_khz,
                                                   input longint unsigned half_steps,
                                                   input int unsigned sel);
        longint unsigned r;
        r = ref_khz / (2 * half_steps * mod_khz(sel));
        return (r < 1) ? 64'd1 : r;
    endfunction

    // offset increment per step
    function automatic longint unsigned step_size(input int unsigned ofs_w,
                                                   input longint unsigned half_steps,
                                                   input int unsigned sel);
        longint unsigned s;
        s = (spread_ppm(sel) << ofs_w) / (64'd1000000 * half_steps);
        return (s < 1) ? 64'd1 : s;
    endfunction

endpackage

// File: rtl/tpg_cfg.sv
module tpg_cfg
    import tpg_pkg::*;
#(
    parameter int REF_KHZ    = 100000,
    parameter int HALF_STEPS = 64,
    parameter int OFS_W      = 16,
    parameter int DIV_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [SEL_W-1:0] fsel_i,
    input  logic [SEL_W-1:0] ssel_i,
    output logic [DIV_W-1:0] ratio_o,
    output logic [OFS_W-1:0] step_sz_o,
    output logic [OFS_W-1:0] peak_o
);

    typedef struct packed {
        logic [SEL_W-1:0] fsel;
        logic [SEL_W-1:0] ssel;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic [DIV_W-1:0] ratio_tab [N_SEL];
    logic [OFS_W-1:0] step_tab  [N_SEL];
    logic [OFS_W-1:0] peak_tab  [N_SEL];

    for (genvar g = 0; g < N_SEL; g++) begin : g_tab
        assign ratio_tab[g] = DIV_W'(div_ratio(64'(REF_KHZ), 64'(HALF_STEPS), g));
        assign step_tab[g]  = OFS_W'(step_size(OFS_W, 64'(HALF_STEPS), g));
        assign peak_tab[g]  = OFS_W'(step_size(OFS_W, 64'(HALF_STEPS), g) * 64'(HALF_STEPS));
    end

    always_comb begin
        cfg_d = cfg_q;
        if (load_i) begin
            cfg_d.fsel = fsel_i;
            cfg_d.ssel = ssel_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign ratio_o   = ratio_tab[cfg_q.fsel];
    assign step_sz_o = step_tab[cfg_q.ssel];
    assign peak_o    = peak_tab[cfg_q.ssel];

endmodule

// File: rtl/tpg_step_div.sv
module tpg_step_div #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] ratio_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q >= ratio_i - DIV_W'(1));
        if (!run_i || tick_o) cnt_d = '0;
        else                  cnt_d = cnt_q + DIV_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/tpg_ramp.sv
module tpg_ramp
    import tpg_pkg::*;
#(
    parameter int OFS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             tick_i,
    input  logic [OFS_W-1:0] step_sz_i,
    input  logic [OFS_W-1:0] peak_i,
    output logic [OFS_W-1:0] ofs_o,
    output logic             stepped_o,
    output logic             top_o,
    output logic             bottom_o
);

    localparam int SUM_W = OFS_W + 1;

    typedef struct packed {
        logic [OFS_W-1:0] ofs;
        ramp_dir_e        dir;
        logic             stepped;
    } ramp_t;

    ramp_t ramp_d, ramp_q;
    logic [SUM_W-1:0] rise_sum;

    always_comb begin
        ramp_d         = ramp_q;
        ramp_d.stepped = 1'b0;
        rise_sum       = {1'b0, ramp_q.ofs} + {1'b0, step_sz_i};
        if (clear_i) begin
            ramp_d.ofs = '0;
            ramp_d.dir = DIR_UP;
        end else if (tick_i) begin
            ramp_d.stepped = 1'b1;
            if (ramp_q.dir == DIR_UP) begin
                if (rise_sum >= {1'b0, peak_i}) begin
                    ramp_d.ofs = peak_i;
                    ramp_d.dir = DIR_DOWN;
                end else begin
                    ramp_d.ofs = rise_sum[OFS_W-1:0];
                end
            end else begin
                if (ramp_q.ofs <= step_sz_i) begin
                    ramp_d.ofs = '0;
                    ramp_d.dir = DIR_UP;
                end else begin
                    ramp_d.ofs = ramp_q.ofs - step_sz_i;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ramp_q <= '{ofs: '0, dir: DIR_UP, stepped: 1'b0};
        else        ramp_q <= ramp_d;
    end

    assign ofs_o     = ramp_q.ofs;
    assign stepped_o = ramp_q.stepped;
    assign top_o     = (ramp_q.ofs == peak_i) && (peak_i != '0);
    assign bottom_o  = (ramp_q.ofs == '0);

endmodule

// File: rtl/tri_profile_gen.sv
module tri_profile_gen
    import tpg_pkg::*;
#(
    parameter int REF_KHZ    = 100000,
    parameter int HALF_STEPS = 64,
    parameter int OFS_W      = 16,
    parameter int DIV_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             bypass_i,
    input  logic [SEL_W-1:0] fmod_sel_i,
    input  logic [SEL_W-1:0] spread_sel_i,
    output logic [OFS_W-1:0] offset_o,
    output logic             step_o,
    output logic             at_top_o,
    output logic             at_bottom_o
);

    logic [DIV_W-1:0] ratio_w;
    logic [OFS_W-1:0] step_sz_w;
    logic [OFS_W-1:0] peak_w;
    logic             tick_w;
    logic             run_w;
    logic             load_w;
    logic             bottom_w;

    // keep stepping until the triangle closes at zero
    assign run_w  = !bypass_i && (start_i || !bottom_w);
    // capture selects only in a resting zero cycle
    assign load_w = bottom_w && !tick_w;

    tpg_cfg #(
        .REF_KHZ    (REF_KHZ),
        .HALF_STEPS (HALF_STEPS),
        .OFS_W      (OFS_W),
        .DIV_W      (DIV_W)
    ) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load_w),
        .fsel_i    (fmod_sel_i),
        .ssel_i    (spread_sel_i),
        .ratio_o   (ratio_w),
        .step_sz_o (step_sz_w),
        .peak_o    (peak_w)
    );

    tpg_step_div #(
        .DIV_W (DIV_W)
    ) div_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run_w),
        .ratio_i (ratio_w),
        .tick_o  (tick_w)
    );

    tpg_ramp #(
        .OFS_W (OFS_W)
    ) ramp_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (bypass_i),
        .tick_i    (tick_w),
        .step_sz_i (step_sz_w),
        .peak_i    (peak_w),
        .ofs_o     (offset_o),
        .stepped_o (step_o),
        .top_o     (at_top_o),
        .bottom_o  (bottom_w)
    );

    assign at_bottom_o = bottom_w;

endmodule

// File: rtl/tpg_chk.sv
module tpg_chk #(
    parameter int OFS_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             bypass_i,
    input logic [OFS_W-1:0] offset_o,
    input logic             step_o,
    input logic             at_top_o,
    input logic [OFS_W-1:0] peak_i,
    input logic [OFS_W-1:0] step_sz_i
);

    // R4: the offset stays within the programmed peak
    p_no_overshoot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        offset_o <= peak_i);

    // R6: reaching the top only happens through a step
    p_top_on_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(at_top_o) |-> step_o);

    // R6: the offset is quiet between steps unless bypass cleared it
    p_quiet_between_steps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_o && !$past(bypass_i)) |-> $stable(offset_o));

    // R3: a rising step never exceeds the active step size
    p_step_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o && (offset_o > $past(offset_o))) |->
            ((offset_o - $past(offset_o)) <= $past(step_sz_i)));

    // R11: bypass clears the offset and suppresses steps
    p_bypass_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bypass_i) |-> (offset_o == '0 && !step_o));

    // R7: the peak cannot change while the ramp is away from zero
    p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (offset_o != '0) |=> $stable(peak_i));

    // R9 / R10: a stopped ramp resting at zero produces no step
    p_park_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && offset_o == '0) |=> !step_o);

endmodule

bind tri_profile_gen tpg_chk #(
    .OFS_W (OFS_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .bypass_i  (bypass_i),
    .offset_o  (offset_o),
    .step_o    (step_o),
    .at_top_o  (at_top_o),
    .peak_i    (peak_w),
    .step_sz_i (step_sz_w)
);

// File: tb/tri_profile_gen_tb_top.sv
module tri_profile_gen_tb_top;

    localparam int OFS_W  = 16;
    localparam int HS     = 64;
    localparam int CLK_NS = 20;
    localparam int NVEC   = 4;

    // vectors: fmod select, spread select, expected interval, expected step size
    localparam int V_F     [NVEC] = '{0, 1, 2, 3};
    localparam int V_S     [NVEC] = '{3, 2, 1, 0};
    localparam int V_RATIO [NVEC] = '{26, 13, 5, 2};
    localparam int V_STEP  [NVEC] = '{51, 25, 10, 2};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             bypass_i = 1'b0;
    logic [1:0]       fmod_sel_i = '0;
    logic [1:0]       spread_sel_i = '0;
    logic [OFS_W-1:0] offset_o;
    logic             step_o;
    logic             at_top_o;
    logic             at_bottom_o;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_NS/2) clk = ~clk;

    tri_profile_gen dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .bypass_i     (bypass_i),
        .fmod_sel_i   (fmod_sel_i),
        .spread_sel_i (spread_sel_i),
        .offset_o     (offset_o),
        .step_o       (step_o),
        .at_top_o     (at_top_o),
        .at_bottom_o  (at_bottom_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // wait for the next step pulse, watching the offset in between (R6)
    task automatic wait_step(output int cyc);
        logic [OFS_W-1:0] prev;
        bit moved;
        prev  = offset_o;
        moved = 1'b0;
        cyc   = 0;
        do begin
            @(negedge clk);
            cyc++;
            if (!step_o && offset_o != prev) moved = 1'b1;
        end while (!step_o && cyc < 5000);
        if (moved) chk(1'b0, "R6", "offset moved without step", offset_o, prev);
    endtask

    task automatic settle(input int f, input int s);
        @(negedge clk);
        bypass_i     = 1'b1;
        start_i      = 1'b0;
        fmod_sel_i   = 2'(f);
        spread_sel_i = 2'(s);
        repeat (3) @(negedge clk);
        bypass_i = 1'b0;
    endtask

    task automatic run_steps(input int n);
        int c;
        for (int i = 0; i < n; i++) wait_step(c);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        chk(1'b0, "R0", "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin : main
        int cyc;
        int exp;
        int cnt;
        bit bad;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(offset_o == 0, "R1", "offset after reset", offset_o, 0);
        chk(at_bottom_o == 1'b1, "R1", "at_bottom after reset", at_bottom_o, 1);
        chk(at_top_o == 1'b0, "R1", "at_top after reset", at_top_o, 0);
        chk(step_o == 1'b0, "R1", "step after reset", step_o, 0);

        // R10: idle with start low
        bad = 1'b0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (step_o || offset_o != 0) bad = 1'b1;
        end
        chk(!bad, "R10", "idle ramp stepped", bad, 0);

        // table walk: one full triangle per vector (R2 R3 R4 R5)
        for (int v = 0; v < NVEC; v++) begin
            settle(V_F[v], V_S[v]);
            start_i = 1'b1;
            for (int k = 1; k <= 2*HS; k++) begin
                wait_step(cyc);
                exp = (k <= HS) ? k*V_STEP[v] : (2*HS-k)*V_STEP[v];
                chk(offset_o == exp, (k <= HS) ? "R3" : "R5", "ramp offset", offset_o, exp);
                chk(cyc == V_RATIO[v], "R2", "step interval", cyc, V_RATIO[v]);
                if (k == HS)   chk(at_top_o == 1'b1, "R4", "at_top at peak", at_top_o, 1);
                if (k == HS+1) chk(at_top_o == 1'b0, "R4", "at_top after peak", at_top_o, 0);
                if (k == 2*HS) chk(at_bottom_o == 1'b1, "R5", "at_bottom at end", at_bottom_o, 1);
            end
            start_i = 1'b0;
        end

        // R7: select change mid-ramp, then R9: stop mid-ramp
        settle(3, 1);
        start_i = 1'b1;
        run_steps(5);
        spread_sel_i = 2'd3;
        wait_step(cyc);
        chk(offset_o == 60, "R7", "old step kept mid-ramp", offset_o, 60);
        run_steps(122);
        chk(offset_o == 0, "R7", "triangle closes at zero", offset_o, 0);
        wait_step(cyc);
        chk(offset_o == 51, "R7", "new step after zero", offset_o, 51);
        start_i = 1'b0;
        cnt = 0;
        do begin
            wait_step(cyc);
            cnt++;
        end while (offset_o != 0 && cnt < 300);
        chk(cnt == 127, "R9", "steps to finish after stop", cnt, 127);
        bad = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (step_o || offset_o != 0) bad = 1'b1;
        end
        chk(!bad, "R9", "parked ramp stepped", bad, 0);

        // R8: select change in the cycle that leaves zero
        settle(3, 1);
        start_i = 1'b1;
        run_steps(128);
        chk(offset_o == 0, "R8", "at zero before change", offset_o, 0);
        @(negedge clk);
        spread_sel_i = 2'd3;
        wait_step(cyc);
        chk(offset_o == 10, "R8", "leaving step uses old size", offset_o, 10);
        run_steps(63);
        chk(offset_o == 640, "R8", "old peak kept", offset_o, 640);
        chk(at_top_o == 1'b1, "R8", "at_top at old peak", at_top_o, 1);
        run_steps(64);
        chk(offset_o == 0, "R8", "back at zero", offset_o, 0);
        wait_step(cyc);
        chk(offset_o == 51, "R8", "new size on next triangle", offset_o, 51);
        start_i = 1'b0;
        cnt = 0;
        do begin
            wait_step(cyc);
            cnt++;
        end while (offset_o != 0 && cnt < 300);

        // R11: bypass mid-ramp and release
        settle(3, 1);
        start_i = 1'b1;
        run_steps(20);
        chk(offset_o == 200, "R11", "offset before bypass", offset_o, 200);
        bypass_i = 1'b1;
        @(negedge clk);
        chk(offset_o == 0, "R11", "offset cleared by bypass", offset_o, 0);
        chk(step_o == 1'b0, "R11", "no step under bypass", step_o, 0);
        bad = 1'b0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (step_o || offset_o != 0) bad = 1'b1;
        end
        chk(!bad, "R11", "activity under bypass", bad, 0);
        bypass_i = 1'b0;
        wait_step(cyc);
        chk(offset_o == 10, "R11", "restart from zero", offset_o, 10);
        chk(cyc == 2, "R11", "restart interval", cyc, 2);
        start_i  = 1'b0;
        bypass_i = 1'b1;
        repeat (3) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule